// File: doc/BRIEF.md
# Tag/Port-ID Associative Store with Per-Word Valid Bits

This block is a small associative store. Each of its twenty word slots holds an 8-bit key, a 4-bit port ID and a valid bit. A 2-bit operation code and a 5-bit address arrive together on every rising clock edge, and exactly one operation runs per cycle. A read is the idle operation because it changes no state.

The address is decoded as a grid. The upper three bits pick one of five row groups and the lower two bits pick one of four lines inside that group. Only one wordline can be active at a time. Address 31 is reserved and never reaches a word slot. A write to address 31 loads a separate register with the port ID that a failed search returns. A delete to address 31 wipes every valid bit in one cycle and raises a clear indication for that cycle. Addresses 20 to 30 select no word.

A search compares the key against every valid word. It returns the port ID of the lowest-numbered match together with a hit flag. On a miss it returns the contents of the reserved register with the hit flag low.

Top module: `tag_cam`

## Requirements
- R1: The operation codes are 0 = write, 1 = search, 2 = read and 3 = delete. `wr_en` is high in the same cycle for write, search and delete, and low for read.
- R2: `wordline` is combinational. For write, read or delete to an address a below 20 it has exactly bit (a>>2)*4 + (a&3) set. For a search, for address 31 and for addresses 20 to 30 it is all zero.
- R3: A write to an address below 20 stores `key_in` and `port_in` in that word and sets the word's valid bit at the clock edge.
- R4: A write to address 31 loads `port_in` into the no-match register and changes no word slot.
- R5: The result outputs update at the clock edge that ends a read. A read of word a returns that word's key, port and valid bit on `q_key`, `q_port` and `q_vld`, with `q_hit` = 0. A read of address 31 returns the no-match register on `q_port` and zero on the other result outputs. A read of addresses 20 to 30 returns all zeros.
- R6: The result outputs update at the clock edge that ends a search. If any valid word's key equals `key_in`, `q_hit` = 1 and `q_port` is the port of the lowest-indexed such word. `q_key` and `q_vld` are 0.
- R7: A delete to an address below 20 clears only that word's valid bit.
- R8: A delete to address 31 clears every valid bit at the clock edge. `clr_all` is high in that cycle and in no other.
- R9: A search with no valid match gives `q_hit` = 0 and `q_port` equal to the no-match register.
- R10: Write and delete leave `q_key`, `q_port`, `q_hit` and `q_vld` unchanged.
- R11: A synchronous reset clears all valid bits, all stored keys and ports, the no-match register and all result outputs.
- R12: A write or delete to an address from 20 to 30 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 2 | Operation code |
| addr | input | 5 | Word address; 31 is reserved |
| key_in | input | 8 | Key to store or search for |
| port_in | input | 4 | Port ID to store |
| wordline | output | 20 | Decoded word select, one-hot or zero |
| wr_en | output | 1 | Array write strobe |
| clr_all | output | 1 | Global valid clear in this cycle |
| q_key | output | 8 | Registered read key |
| q_port | output | 4 | Registered read or search port ID |
| q_hit | output | 1 | Registered search hit flag |
| q_vld | output | 1 | Registered valid bit of the word read |

## Verification
`wordline`, `wr_en` and `clr_all` are due in the same cycle as the operation. The bench samples them 1 ns after it drives the inputs on the falling edge. The read and search results come one rising edge later. The bench computes their expected values from its model state before the operation, then samples 1 ns after the next rising edge. Only after that does it update the model. State changes from write, delete and clear show up at the earliest on the operation that follows. Each such check is therefore made through a later read or search, which sees the state from the previous edge.

// File: rtl/tag_cam_pkg.sv
package tag_cam_pkg;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SEARCH = 2'd1,
    OP_READ   = 2'd2,
    OP_DELETE = 2'd3
  } cam_op_e;

  // linear word number from a grid row and column
  function automatic int unsigned grid_index(input int unsigned row,
                                             input int unsigned col,
                                             input int unsigned cols);
    return row * cols + col;
  endfunction

endpackage

// File: rtl/cam_addr_dec.sv
module cam_addr_dec #(
  parameter int ADDR_W   = 5,
  parameter int ROWS     = 5,
  parameter int COLS     = 4,
  parameter int RSV_ADDR = 31,
  localparam int WORDS   = ROWS * COLS
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORDS-1:0]  word_oh,
  output logic              is_rsv
);
  import tag_cam_pkg::*;

  localparam int COL_BITS = $clog2(COLS);
  localparam int ROW_W    = ADDR_W - COL_BITS;

  logic [ROWS-1:0] row_oh;
  logic [COLS-1:0] col_oh;

  assign is_rsv = (addr == ADDR_W'(RSV_ADDR));

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_oh[r] = (addr[ADDR_W-1:COL_BITS] == ROW_W'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_oh[c] = (addr[COL_BITS-1:0] == COL_BITS'(c));
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_gr
    for (genvar c = 0; c < COLS; c++) begin : g_gc
      assign word_oh[grid_index(r, c, COLS)] = row_oh[r] & col_oh[c] & ~is_rsv;
    end
  end

endmodule

// File: rtl/cam_word_array.sv
module cam_word_array #(
  parameter int WORDS  = 20,
  parameter int KEY_W  = 8,
  parameter int PORT_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [WORDS-1:0]              wl,
  input  logic                          we,
  input  logic                          del,
  input  logic                          clr,
  input  logic [KEY_W-1:0]              key_in,
  input  logic [PORT_W-1:0]             port_in,
  output logic [WORDS-1:0][KEY_W-1:0]   keys,
  output logic [WORDS-1:0][PORT_W-1:0]  ports,
  output logic [WORDS-1:0]              valid
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [KEY_W-1:0]  k_q;
    logic [PORT_W-1:0] p_q;
    logic              v_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        k_q <= '0;
        p_q <= '0;
        v_q <= 1'b0;
      end else if (clr) begin
        v_q <= 1'b0;
      end else if (wl[w]) begin
        if (we) begin
          k_q <= key_in;
          p_q <= port_in;
          v_q <= 1'b1;
        end else if (del) begin
          v_q <= 1'b0;
        end
      end
    end

    assign keys[w]  = k_q;
    assign ports[w] = p_q;
    assign valid[w] = v_q;
  end

endmodule

// File: rtl/cam_match_pri.sv
module cam_match_pri #(
  parameter int WORDS  = 20,
  parameter int KEY_W  = 8,
  parameter int PORT_W = 4
) (
  input  logic [WORDS-1:0][KEY_W-1:0]   keys,
  input  logic [WORDS-1:0][PORT_W-1:0]  ports,
  input  logic [WORDS-1:0]              valid,
  input  logic [KEY_W-1:0]              key,
  output logic                          hit,
  output logic [PORT_W-1:0]             hit_port
);
  logic [WORDS-1:0] match;

  for (genvar w = 0; w < WORDS; w++) begin : g_cmp
    assign match[w] = valid[w] && (keys[w] == key);
  end

  // lowest index wins
  always_comb begin
    hit      = 1'b0;
    hit_port = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (!hit && match[w]) begin
        hit      = 1'b1;
        hit_port = ports[w];
      end
    end
  end

endmodule

// File: rtl/tag_cam.sv
module tag_cam #(
  parameter int ADDR_W   = 5,
  parameter int ROWS     = 5,
  parameter int COLS     = 4,
  parameter int KEY_W    = 8,
  parameter int PORT_W   = 4,
  parameter int RSV_ADDR = 31,
  localparam int WORDS   = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KEY_W-1:0]  key_in,
  input  logic [PORT_W-1:0] port_in,
  output logic [WORDS-1:0]  wordline,
  output logic              wr_en,
  output logic              clr_all,
  output logic [KEY_W-1:0]  q_key,
  output logic [PORT_W-1:0] q_port,
  output logic              q_hit,
  output logic              q_vld
);
  import tag_cam_pkg::*;

  cam_op_e op;
  assign op = cam_op_e'(cmd);

  logic [WORDS-1:0] word_oh;
  logic             is_rsv;

  cam_addr_dec #(
    .ADDR_W(ADDR_W), .ROWS(ROWS), .COLS(COLS), .RSV_ADDR(RSV_ADDR)
  ) u_dec (
    .addr(addr), .word_oh(word_oh), .is_rsv(is_rsv)
  );

  // event wires
  logic op_wr, op_del, op_rd, op_srch;
  assign op_wr   = (op == OP_WRITE);
  assign op_del  = (op == OP_DELETE);
  assign op_rd   = (op == OP_READ);
  assign op_srch = (op == OP_SEARCH);

  assign wordline = op_srch ? '0 : word_oh;
  assign wr_en    = !op_rd;
  assign clr_all  = op_del && is_rsv;

  logic                         nm_load;
  logic [PORT_W-1:0]            nm_port;
  logic [WORDS-1:0][KEY_W-1:0]  keys;
  logic [WORDS-1:0][PORT_W-1:0] ports;
  logic [WORDS-1:0]             valid_q;

  assign nm_load = op_wr && is_rsv;

  cam_word_array #(
    .WORDS(WORDS), .KEY_W(KEY_W), .PORT_W(PORT_W)
  ) u_arr (
    .clk(clk), .rst(rst), .wl(wordline), .we(op_wr), .del(op_del),
    .clr(clr_all), .key_in(key_in), .port_in(port_in),
    .keys(keys), .ports(ports), .valid(valid_q)
  );

  logic              srch_hit;
  logic [PORT_W-1:0] srch_port;

  cam_match_pri #(
    .WORDS(WORDS), .KEY_W(KEY_W), .PORT_W(PORT_W)
  ) u_pri (
    .keys(keys), .ports(ports), .valid(valid_q), .key(key_in),
    .hit(srch_hit), .hit_port(srch_port)
  );

  always_ff @(posedge clk) begin
    if (rst)          nm_port <= '0;
    else if (nm_load) nm_port <= port_in;
  end

  // one-hot read mux
  logic [KEY_W-1:0]  rd_key;
  logic [PORT_W-1:0] rd_port;
  logic              rd_vld;

  always_comb begin
    rd_key  = '0;
    rd_port = '0;
    rd_vld  = 1'b0;
    for (int w = 0; w < WORDS; w++) begin
      if (wordline[w]) begin
        rd_key  = rd_key  | keys[w];
        rd_port = rd_port | ports[w];
        rd_vld  = rd_vld  | valid_q[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_key  <= '0;
      q_port <= '0;
      q_hit  <= 1'b0;
      q_vld  <= 1'b0;
    end else if (op_rd) begin
      q_key  <= rd_key;
      q_port <= is_rsv ? nm_port : rd_port;
      q_hit  <= 1'b0;
      q_vld  <= rd_vld;
    end else if (op_srch) begin
      q_key  <= '0;
      q_port <= srch_hit ? srch_port : nm_port;
      q_hit  <= srch_hit;
      q_vld  <= 1'b0;
    end
  end

endmodule

// File: rtl/tag_cam_chk.sv
module tag_cam_chk #(
  parameter int WORDS  = 20,
  parameter int KEY_W  = 8,
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cmd,
  input logic [WORDS-1:0]  wordline,
  input logic              clr_all,
  input logic [WORDS-1:0]  valid_vec,
  input logic [PORT_W-1:0] nm_port,
  input logic [KEY_W-1:0]  q_key,
  input logic [PORT_W-1:0] q_port,
  input logic              q_hit,
  input logic              q_vld
);

  p_wl_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wordline));

  p_search_no_wl_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd1) |-> (wordline == '0));

  p_write_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd0 && wordline != '0) |=> ((valid_vec & $past(wordline)) == $past(wordline)));

  p_delete_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd3 && wordline != '0) |=> ((valid_vec & $past(wordline)) == '0));

  p_clear_all_r8: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (valid_vec == '0));

  p_miss_port_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd1) |=> (q_hit || (q_port == $past(nm_port))));

  p_hold_results_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd0 || cmd == 2'd3) |=>
      ($stable(q_key) && $stable(q_port) && $stable(q_hit) && $stable(q_vld)));

endmodule

bind tag_cam tag_cam_chk #(
  .WORDS(WORDS), .KEY_W(KEY_W), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .wordline(wordline), .clr_all(clr_all),
  .valid_vec(valid_q), .nm_port(nm_port), .q_key(q_key), .q_port(q_port),
  .q_hit(q_hit), .q_vld(q_vld)
);

// File: tb/tag_cam_bench.sv
module tag_cam_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cmd = 2'd2;
  logic [4:0]  addr = '0;
  logic [7:0]  key_in = '0;
  logic [3:0]  port_in = '0;
  logic [19:0] wordline;
  logic        wr_en, clr_all, q_hit, q_vld;
  logic [7:0]  q_key;
  logic [3:0]  q_port;

  tag_cam u_tag_cam (
    .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .key_in(key_in),
    .port_in(port_in), .wordline(wordline), .wr_en(wr_en), .clr_all(clr_all),
    .q_key(q_key), .q_port(q_port), .q_hit(q_hit), .q_vld(q_vld)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_key [20];
  logic [3:0] m_port[20];
  logic       m_vld [20];
  logic [3:0] m_nm;
  logic [7:0] e_key;
  logic [3:0] e_port;
  logic       e_hit, e_vld;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int widx(logic [4:0] a);
    if (a < 5'd20) return int'(a[4:2]) * 4 + int'(a[1:0]);
    return -1;
  endfunction

  function automatic logic [19:0] exp_wl(logic [1:0] c, logic [4:0] a);
    int i = widx(a);
    if (c == 2'd1 || i < 0) return '0;
    return 20'd1 << i;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 20; i++) begin
      m_key[i] = '0; m_port[i] = '0; m_vld[i] = 1'b0;
    end
    m_nm = '0;
    e_key = '0; e_port = '0; e_hit = 1'b0; e_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd = 2'd2;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R11", "q_key", 32'(q_key), 0);
    check("R11", "q_port", 32'(q_port), 0);
    check("R11", "q_hit", 32'(q_hit), 0);
    check("R11", "q_vld", 32'(q_vld), 0);
  endtask

  task automatic do_op(logic [1:0] c, logic [4:0] a, logic [7:0] k, logic [3:0] p);
    int i;
    @(negedge clk);
    cmd = c; addr = a; key_in = k; port_in = p;
    #1;
    check("R2", "wordline", 32'(wordline), 32'(exp_wl(c, a)));
    check("R1", "wr_en", 32'(wr_en), 32'(c != 2'd2));
    check("R8", "clr_all", 32'(clr_all), 32'(c == 2'd3 && a == 5'd31));
    i = widx(a);
    case (c)
      2'd2: begin
        e_hit = 1'b0;
        if (a == 5'd31) begin e_key = '0; e_port = m_nm; e_vld = 1'b0; end
        else if (i < 0) begin e_key = '0; e_port = '0; e_vld = 1'b0; end
        else begin e_key = m_key[i]; e_port = m_port[i]; e_vld = m_vld[i]; end
      end
      2'd1: begin
        e_key = '0; e_vld = 1'b0; e_hit = 1'b0; e_port = m_nm;
        for (int w = 0; w < 20; w++)
          if (!e_hit && m_vld[w] && m_key[w] == k) begin e_hit = 1'b1; e_port = m_port[w]; end
      end
      2'd0: begin
        if (a == 5'd31) m_nm = p;
        else if (i >= 0) begin m_key[i] = k; m_port[i] = p; m_vld[i] = 1'b1; end
      end
      default: begin
        if (a == 5'd31) for (int w = 0; w < 20; w++) m_vld[w] = 1'b0;
        else if (i >= 0) m_vld[i] = 1'b0;
      end
    endcase
    @(posedge clk);
    #1;
    begin
      string tag;
      tag = (c == 2'd2) ? "R5" : (c == 2'd1) ? (e_hit ? "R6" : "R9") : "R10";
      check(tag, "q_key", 32'(q_key), 32'(e_key));
      check(tag, "q_port", 32'(q_port), 32'(e_port));
      check(tag, "q_hit", 32'(q_hit), 32'(e_hit));
      check(tag, "q_vld", 32'(q_vld), 32'(e_vld));
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    model_reset();
    do_reset();
    // R11: every slot reads back empty after reset
    for (int a = 0; a < 20; a++) do_op(2'd2, 5'(a), 8'h00, 4'h0);
    do_op(2'd2, 5'd31, 8'h00, 4'h0);
    // R3 / R6: same key in words 0 and 19, lowest wins
    do_op(2'd0, 5'd19, 8'hA5, 4'h9);
    do_op(2'd0, 5'd0,  8'hA5, 4'h3);
    do_op(2'd1, 5'd7,  8'hA5, 4'h0);
    // R7: delete word 0 only, search falls to 19
    do_op(2'd3, 5'd0,  8'h00, 4'h0);
    do_op(2'd1, 5'd0,  8'hA5, 4'h0);
    do_op(2'd2, 5'd19, 8'h00, 4'h0);
    // R4: load no-match register, R9 miss
    do_op(2'd0, 5'd31, 8'hA5, 4'hC);
    do_op(2'd2, 5'd31, 8'h00, 4'h0);
    do_op(2'd1, 5'd3,  8'h5A, 4'h0);
    // R12: writes and deletes to 20..30 are ignored
    do_op(2'd0, 5'd25, 8'h77, 4'h1);
    do_op(2'd1, 5'd0,  8'h77, 4'h0);
    do_op(2'd3, 5'd20, 8'h00, 4'h0);
    do_op(2'd1, 5'd0,  8'hA5, 4'h0);
    do_op(2'd2, 5'd30, 8'h00, 4'h0);
    // R8: global clear
    do_op(2'd3, 5'd31, 8'h00, 4'h0);
    do_op(2'd1, 5'd0,  8'hA5, 4'h0);
    do_op(2'd2, 5'd19, 8'h00, 4'h0);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [1:0] c;
      logic [4:0] a;
      int r = int'($urandom % 100);
      c = (r < 35) ? 2'd0 : (r < 65) ? 2'd1 : (r < 85) ? 2'd2 : 2'd3;
      a = ($urandom % 10 == 0) ? 5'(20 + $urandom % 12) : 5'($urandom % 20);
      if (c == 2'd3 && a == 5'd31 && ($urandom % 4 != 0)) a = 5'($urandom % 20);
      do_op(c, a, 8'($urandom % 12), 4'($urandom));
      if (n == 750) begin
        do_reset();
        do_op(2'd1, 5'd0, 8'h03, 4'h0);
        do_op(2'd2, 5'd31, 8'h00, 4'h0);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule